// File: doc/BRIEF.md
# Receive Preamble and Delimiter Gate

This block sits at the start of an Ethernet receive path. It watches the receive data-valid line and the receive data. It decides whether each frame opens with a valid preamble followed by a start-of-frame delimiter. Frames that pass are forwarded downstream with the header removed, and a one-cycle start pulse marks the first body sample. Frames that fail are held back completely, and an ignore flag stays raised until data-valid falls.

There are two input widths. In serial mode one bit arrives per cycle on `rx_d_i[0]`. The first bit times are not examined. A short window of strict alternation follows, and then the block searches for a pair of ones that marks the delimiter. In nibble mode four bits arrive per cycle. Two nibbles, low nibble first, form a byte. Any number of 0x55 bytes may come first, and the 0xD5 byte ends the header. In both modes bits are in wire order, least significant first. Address filtering, CRC checking and buffering belong to later stages.

Top module: `rx_sfd_gate`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `rx_dv_i` low, the outputs `sof_o`, `data_vld_o`, `ignore_o` and `data_o` are all zero.
- R2: In serial mode (`mode_nib_i`=0), bit time 1 is the first cycle in which `rx_dv_i` is high. Bit times 1 to 16 are not examined, so any values there, including equal pairs that span into bit 17, are accepted.
- R3: In serial mode, two equal adjacent bits where both fall within bit times 17 to 21 reject the frame. The pair made of bits 21 and 22 lies outside this window.
- R4: In serial mode, from bit time 22 on, a bit that is 1 and follows a 1 completes the delimiter. The next bit is the first body bit. Body bits appear on `data_o[0]` with `data_o[3:1]` zero, one cycle after they are sampled. Alternating bits keep the search going.
- R5: In serial mode, from bit time 22 on, a bit that is 0 and follows a 0 before the delimiter rejects the frame.
- R6: In nibble mode (`mode_nib_i`=1), nibble pairs form bytes with the first nibble in bits [3:0]. Zero or more 0x55 bytes followed by 0xD5 complete the header. Any other completed byte rejects the frame.
- R7: In nibble mode, the bit stream runs bit 0 to bit 3 within each nibble, and bit 3 of one nibble is followed by bit 0 of the next. Two adjacent zeros anywhere in this stream before the delimiter reject the frame at the nibble where they appear, even if that nibble is the first of a byte.
- R8: Header samples are never forwarded. `data_vld_o` follows `rx_dv_i` through the body. `sof_o` pulses once, together with the first body sample. `data_o` is zero whenever `data_vld_o` is low.
- R9: On rejection, `ignore_o` rises in the cycle after the offending sample. It stays high with no body output while `rx_dv_i` remains high, and it clears one cycle after `rx_dv_i` is sampled low.
- R10: A low `rx_dv_i` at any point returns the block to idle without raising `ignore_o`. A new frame may begin in the very next cycle. If data-valid drops straight after the delimiter, no `sof_o` is produced.
- R11: `mode_nib_i` is sampled only while idle. Changing it in the middle of a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_nib_i | input | 1 | 0 = serial bit mode, 1 = 4-bit nibble mode |
| rx_dv_i | input | 1 | Receive data valid |
| rx_d_i | input | 4 | Receive data (bit 0 only in serial mode) |
| sof_o | output | 1 | Pulse with the first forwarded body sample |
| data_vld_o | output | 1 | Forwarded body sample valid |
| data_o | output | 4 | Forwarded body sample |
| ignore_o | output | 1 | Current frame rejected, held until data-valid falls |

## Verification
Two checks can act on the same sample. In serial mode, the alternation rule and the delimiter search meet at the boundary between bit 21 and bit 22. The bench sends a pair of ones at bits 20–21, which must reject, and a pair of ones at bits 21–22, which must complete the delimiter. In nibble mode, a second nibble such as 0x1 produces both a zero pair and a wrong byte in one cycle. A 0x6 in the first-nibble position produces a zero pair only across the nibble boundary. For each of these the bench judges the exact number of ignored cycles and confirms that no body output appears.

// File: rtl/rx_sfd_pkg.sv
package rx_sfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_BODY = 2'd2,
    ST_DROP = 2'd3
  } gate_st_e;

  typedef struct packed {
    logic hit;
    logic bad;
  } hdr_res_t;
endpackage

// File: rtl/rx_sfd_ser.sv
module rx_sfd_ser
  import rx_sfd_pkg::*;
#(
  parameter int LEAD_BITS = 16,
  parameter int ALT_BITS  = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     first_i,
  input  logic     en_i,
  input  logic     bit_i,
  output hdr_res_t res_o
);
  localparam int WIN_END = LEAD_BITS + ALT_BITS;
  localparam int CW      = $clog2(WIN_END + 2);

  logic [CW-1:0] cnt_q, cnt_eff, bt;
  logic          prev_q, prev_eff;
  logic          in_win, post_win;

  // first_i: current sample is bit time 1, registers treated as cleared
  always_comb begin
    cnt_eff  = first_i ? '0 : cnt_q;
    prev_eff = first_i ? 1'b0 : prev_q;
    bt       = cnt_eff + 1'b1;
    in_win   = (int'(bt) > LEAD_BITS + 1) && (int'(bt) <= WIN_END);
    post_win = int'(bt) > WIN_END;
    res_o.bad = en_i & ((in_win & (bit_i == prev_eff)) |
                        (post_win & ~bit_i & ~prev_eff));
    res_o.hit = en_i & post_win & bit_i & prev_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else if (en_i) begin
      prev_q <= bit_i;
      if (int'(cnt_eff) < WIN_END) cnt_q <= cnt_eff + 1'b1;
      else                         cnt_q <= cnt_eff;
    end
  end
endmodule

// File: rtl/rx_sfd_nib.sv
module rx_sfd_nib
  import rx_sfd_pkg::*;
#(
  parameter int              DW       = 4,
  parameter logic [2*DW-1:0] PRE_WORD = 'h55,
  parameter logic [2*DW-1:0] SFD_WORD = 'hD5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_i,
  input  logic          en_i,
  input  logic [DW-1:0] nib_i,
  output hdr_res_t      res_o
);
  localparam int BW = 2 * DW;

  logic          ph_q, ph_eff;
  logic [DW-1:0] lo_q;
  logic          last_q, seen_q, seen_eff;
  logic [DW:0]   chain;
  logic [DW-1:0] zz;
  logic [BW-1:0] word;
  logic          any_zz;

  assign ph_eff   = first_i ? 1'b0 : ph_q;
  assign seen_eff = first_i ? 1'b0 : seen_q;
  assign chain    = {nib_i, last_q};
  assign word     = {nib_i, lo_q};

  // adjacent zero pairs in wire order; pair 0 spans the nibble boundary
  for (genvar i = 0; i < DW; i++) begin : g_pair
    if (i == 0) begin : g_edge
      assign zz[i] = seen_eff & ~chain[0] & ~chain[1];
    end else begin : g_in
      assign zz[i] = ~chain[i] & ~chain[i+1];
    end
  end

  assign any_zz    = |zz;
  assign res_o.bad = en_i & (any_zz | (ph_eff & (word != SFD_WORD) & (word != PRE_WORD)));
  assign res_o.hit = en_i & ph_eff & (word == SFD_WORD) & ~any_zz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      lo_q   <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (en_i) begin
      ph_q   <= ~ph_eff;
      lo_q   <= nib_i;
      last_q <= nib_i[DW-1];
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_sfd_out.sv
module rx_sfd_out #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          body_i,
  input  logic          start_i,
  input  logic          dv_i,
  input  logic          mode_nib_i,
  input  logic [DW-1:0] d_i,
  output logic          sof_o,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  logic          first_q;
  logic          take;
  logic [DW-1:0] d_sel;

  assign take  = body_i & dv_i;
  assign d_sel = mode_nib_i ? d_i : {{(DW-1){1'b0}}, d_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      sof_o   <= 1'b0;
      vld_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      if (start_i)   first_q <= 1'b1;
      else if (take) first_q <= 1'b0;
      sof_o  <= take & first_q;
      vld_o  <= take;
      data_o <= take ? d_sel : '0;
    end
  end
endmodule

// File: rtl/rx_sfd_gate.sv
module rx_sfd_gate
  import rx_sfd_pkg::*;
#(
  parameter int              DW        = 4,
  parameter int              LEAD_BITS = 16,
  parameter int              ALT_BITS  = 5,
  parameter logic [2*DW-1:0] PRE_WORD  = 'h55,
  parameter logic [2*DW-1:0] SFD_WORD  = 'hD5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_nib_i,
  input  logic          rx_dv_i,
  input  logic [DW-1:0] rx_d_i,
  output logic          sof_o,
  output logic          data_vld_o,
  output logic [DW-1:0] data_o,
  output logic          ignore_o
);
  gate_st_e st_q, st_d;
  logic     mode_q, mode_eff, idle, hunt, start;
  hdr_res_t ser_res, nib_res, res;

  assign idle     = (st_q == ST_IDLE);
  assign mode_eff = idle ? mode_nib_i : mode_q;
  assign hunt     = rx_dv_i & (idle | (st_q == ST_HDR));
  assign res      = mode_eff ? nib_res : ser_res;
  assign start    = res.hit & ~res.bad;

  rx_sfd_ser #(.LEAD_BITS(LEAD_BITS), .ALT_BITS(ALT_BITS)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .first_i(idle),
    .en_i   (hunt & ~mode_eff),
    .bit_i  (rx_d_i[0]),
    .res_o  (ser_res)
  );

  rx_sfd_nib #(.DW(DW), .PRE_WORD(PRE_WORD), .SFD_WORD(SFD_WORD)) u_nib (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .first_i(idle),
    .en_i   (hunt & mode_eff),
    .nib_i  (rx_d_i),
    .res_o  (nib_res)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_HDR: begin
        if (!rx_dv_i)     st_d = ST_IDLE;
        else if (res.bad) st_d = ST_DROP;
        else if (start)   st_d = ST_BODY;
        else              st_d = ST_HDR;
      end
      ST_BODY, ST_DROP: if (!rx_dv_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_eff;
    end
  end

  rx_sfd_out #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .body_i    (st_q == ST_BODY),
    .start_i   (start & hunt),
    .dv_i      (rx_dv_i),
    .mode_nib_i(mode_q),
    .d_i       (rx_d_i),
    .sof_o     (sof_o),
    .vld_o     (data_vld_o),
    .data_o    (data_o)
  );

  assign ignore_o = (st_q == ST_DROP);
endmodule

// File: rtl/rx_sfd_gate_chk.sv
module rx_sfd_gate_chk #(
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_dv_i,
  input logic          sof_o,
  input logic          data_vld_o,
  input logic [DW-1:0] data_o,
  input logic          ignore_o
);
  assert_sof_with_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> data_vld_o);

  assert_zero_data_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_vld_o |-> (data_o == '0));

  assert_sof_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  assert_no_data_when_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_o |-> !data_vld_o);

  assert_ignore_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ignore_o && rx_dv_i) |=> ignore_o);

  assert_idle_on_dv_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_i |=> (!ignore_o && !data_vld_o));

  assert_vld_needs_dv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(rx_dv_i));
endmodule

bind rx_sfd_gate rx_sfd_gate_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_dv_i   (rx_dv_i),
  .sof_o     (sof_o),
  .data_vld_o(data_vld_o),
  .data_o    (data_o),
  .ignore_o  (ignore_o)
);

// File: tb/tb_rx_sfd_gate.sv
`timescale 1ns/1ps
module tb_rx_sfd_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_nib = 1'b0;
  logic       rx_dv = 1'b0;
  logic [3:0] rx_d = '0;
  logic       sof, vld, ign;
  logic [3:0] dout;

  int total = 0;
  int bad = 0;
  logic [3:0] buf_d [0:63];
  int buf_n;
  logic [3:0] got [0:63];
  int n_got, n_sof, n_ign, sof_at;

  always #5 clk = ~clk;

  rx_sfd_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_nib_i(mode_nib), .rx_dv_i(rx_dv),
    .rx_d_i(rx_d), .sof_o(sof), .data_vld_o(vld), .data_o(dout), .ignore_o(ign)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    n_got = 0; n_sof = 0; n_ign = 0; sof_at = -1; buf_n = 0;
  endtask

  task automatic step(input logic dv, input logic [3:0] d);
    @(negedge clk);
    rx_dv = dv; rx_d = d;
    @(posedge clk); #1;
    if (vld && n_got < 64) begin got[n_got] = dout; n_got++; end
    if (sof) begin n_sof++; sof_at = n_got - 1; end
    if (ign) n_ign++;
  endtask

  task automatic push(input logic [3:0] d);
    buf_d[buf_n] = d; buf_n++;
  endtask

  task automatic push_ser(input logic b);
    push({3'b101, b});
  endtask

  // switch_at >= 0 flips mode_nib after that many samples
  task automatic send(input logic nib, input int switch_at);
    @(negedge clk); mode_nib = nib;
    for (int i = 0; i < buf_n; i++) begin
      if (i == switch_at) mode_nib = ~nib;
      step(1'b1, buf_d[i]);
    end
    step(1'b0, 4'h0);
    mode_nib = nib;
  endtask

  task automatic chk_body(input string req, input logic nib, input int from);
    chk({req, " body count"}, n_got, buf_n - from);
    chk({req, " sof count"}, n_sof, 1);
    chk({req, " sof on first"}, sof_at, 0);
    chk({req, " no ignore"}, n_ign, 0);
    for (int i = 0; i < n_got; i++)
      chk({req, " body data"}, int'(got[i]),
          nib ? int'(buf_d[from+i]) : int'(buf_d[from+i][0]));
  endtask

  task automatic chk_reject(input string req, input int ign_cycles);
    chk({req, " no body"}, n_got, 0);
    chk({req, " no sof"}, n_sof, 0);
    chk({req, " ignore cycles"}, n_ign, ign_cycles);
    chk({req, " ignore cleared"}, int'(ign), 0);
  endtask

  task automatic ser_hdr(input logic [4:0] win);
    for (int i = 0; i < 16; i++) push_ser(i[1] ^ i[3] ^ (i == 15));
    for (int i = 0; i < 5; i++) push_ser(win[i]);
  endtask

  task automatic t_reset_r1();
    chk("R1 sof", int'(sof), 0);
    chk("R1 vld", int'(vld), 0);
    chk("R1 ign", int'(ign), 0);
    chk("R1 data", int'(dout), 0);
  endtask

  // R2 lead-in has 00/11 and bit16=bit17; R3/R4 11 on bits 21-22 completes
  task automatic t_ser_good_r4();
    clr_cap();
    ser_hdr(5'b10101);
    push_ser(1'b1);
    for (int i = 0; i < 10; i++) push_ser(i[0] ^ i[2]);
    send(1'b0, -1);
    chk_body("R4 R2 serial good", 1'b0, 22);
  endtask

  task automatic t_ser_long_search_r4();
    clr_cap();
    ser_hdr(5'b01010);
    push_ser(1'b1); push_ser(1'b0); push_ser(1'b1); push_ser(1'b1);
    for (int i = 0; i < 6; i++) push_ser(~i[1]);
    send(1'b0, -1);
    chk_body("R4 serial search", 1'b0, 25);
  endtask

  task automatic t_ser_win_r3();
    clr_cap();
    ser_hdr(5'b01001);  // 00 at bits 18-19
    for (int i = 0; i < 8; i++) push_ser(1'b1);
    send(1'b0, -1);
    chk_reject("R3 window 00", buf_n - 18);
    clr_cap();
    ser_hdr(5'b11010);  // 11 at bits 20-21
    push_ser(1'b1);
    for (int i = 0; i < 4; i++) push_ser(1'b0);
    send(1'b0, -1);
    chk_reject("R3 window 11 at 20-21", buf_n - 20);
  endtask

  task automatic t_ser_zero_r5();
    clr_cap();
    ser_hdr(5'b10101);
    push_ser(1'b0); push_ser(1'b0);
    push_ser(1'b1); push_ser(1'b1);
    for (int i = 0; i < 4; i++) push_ser(1'b1);
    send(1'b0, -1);
    chk_reject("R5 serial 00", buf_n - 22);
  endtask

  task automatic t_nib_good_r6();
    clr_cap();
    for (int i = 0; i < 7; i++) push(4'h5);
    push(4'hD);
    push(4'hA); push(4'h3); push(4'h0); push(4'hF); push(4'h7);
    send(1'b1, -1);
    chk_body("R6 R8 nibble good", 1'b1, 8);
    clr_cap();
    push(4'h5); push(4'hD);
    push(4'h1); push(4'h2); push(4'hC);
    send(1'b1, -1);
    chk_body("R6 no preamble", 1'b1, 2);
  endtask

  task automatic t_nib_badbyte_r6();
    clr_cap();
    push(4'h5); push(4'h5); push(4'h5); push(4'h7);
    push(4'h5); push(4'hD); push(4'h9); push(4'h9);
    send(1'b1, -1);
    chk_reject("R6 byte 0x75", buf_n - 3);
  endtask

  task automatic t_nib_zero_r7();
    clr_cap();
    push(4'h5); push(4'h5); push(4'h6);  // 00 only across nibble edge
    push(4'h5); push(4'h5); push(4'hD); push(4'h4);
    send(1'b1, -1);
    chk_reject("R7 edge 00", buf_n - 2);
    clr_cap();
    push(4'h5); push(4'h1);  // 00 inside nibble and wrong byte together
    push(4'h5); push(4'hD); push(4'h8);
    send(1'b1, -1);
    chk_reject("R7 inner 00", buf_n - 1);
  endtask

  task automatic t_dv_drop_r10();
    clr_cap();
    mode_nib = 1'b1;
    step(1'b1, 4'h5); step(1'b1, 4'h5); step(1'b1, 4'h5);
    step(1'b0, 4'h0);
    chk("R10 drop no ignore", n_ign, 0);
    push(4'h5); push(4'hD); push(4'h6); push(4'hE);
    send(1'b1, -1);
    chk_body("R10 back-to-back", 1'b1, 2);
    clr_cap();
    push(4'h5); push(4'h5); push(4'h5); push(4'hD);
    send(1'b1, -1);
    chk("R10 drop after sfd sof", n_sof, 0);
    chk("R10 drop after sfd data", n_got, 0);
    chk("R10 drop after sfd ign", n_ign, 0);
  endtask

  task automatic t_mode_r11();
    clr_cap();
    push(4'h5); push(4'h5); push(4'h5); push(4'hD);
    push(4'hB); push(4'h2); push(4'h9);
    send(1'b1, 1);
    chk_body("R11 nib with mode flip", 1'b1, 4);
    clr_cap();
    ser_hdr(5'b10101);
    push_ser(1'b1);
    for (int i = 0; i < 5; i++) push_ser(i[0]);
    send(1'b0, 3);
    chk_body("R11 ser with mode flip", 1'b0, 22);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr_cap();
    #1;
    t_reset_r1();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    t_reset_r1();
    t_ser_good_r4();
    t_ser_long_search_r4();
    t_ser_win_r3();
    t_ser_zero_r5();
    t_nib_good_r6();
    t_nib_badbyte_r6();
    t_nib_zero_r7();
    t_dv_drop_r10();
    t_mode_r11();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule